// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block is the digital control side of a two-channel sampling converter. A falling edge on the active-low start input begins one conversion cycle. The cycle always runs three phases in fixed order: an acquire phase, a channel A conversion and a channel B conversion. Each phase lasts a number of clock cycles set by a parameter. The analog part is not modelled. Each channel's result is the input word present on its sample port in the last cycle of that channel's phase. That word is latched into a per-channel result register. After each latch, a one-cycle completion pulse is issued, together with a flag naming the channel.

A host reads the results over a parallel bus. The bus is enabled only when both the active-low chip-select and the active-low read inputs are low. A channel-select line picks which of the two results is driven. Holding select and read low permanently gives a continuously driven bus that follows each new result.

Power-down is a level input. It cannot cut a running conversion short; it only blocks new ones. A synchronous reset aborts any conversion. If the start input is still low when a conversion finishes, the block starts the next one by itself and keeps doing so while start stays low.

Top module: `dual_adc_seq`

## Requirements
- R1: When the block is idle, not powered down and not in reset, a conversion starts on a start edge. A start edge is `start_n` sampled high on one clock edge and low on the next. `busy` reads 1 from the clock edge that samples the low.
- R2: `busy` stays high for exactly ACQ_CYC + CONVA_CYC + CONVB_CYC cycles. It then drops in the same clock edge that latches channel B.
- R3: `eoc` is a single-cycle pulse, issued once per channel in each conversion. `eoc_chan` reads 0 with the channel A pulse and 1 with the channel B pulse, and holds its value between pulses.
- R4: The channel A result equals `sample_a` as sampled on the last clock edge of the channel A phase. The channel B result equals `sample_b` on the last edge of the channel B phase.
- R5: A start edge that arrives while `busy` is high is not queued. If `start_n` is high again by the time the conversion ends, no further conversion runs.
- R6: Raising `pwr_dn` during a conversion does not shorten it. While the block is idle with `pwr_dn` high, start edges are ignored.
- R7: If `start_n` is low on the clock edge where channel B completes, `busy` is low for exactly one cycle and then a new conversion begins. This repeats for as long as `start_n` stays low.
- R8: `data_oe` is 1 exactly one cycle after a cycle in which both `cs_n` and `rd_n` were low, and 0 otherwise. `data_out` is all zeros whenever `data_oe` is 0.
- R9: When the bus is enabled, `data_out` carries the channel A result when `chan_sel` was 0 in the previous cycle, and the channel B result when it was 1.
- R10: With `cs_n` and `rd_n` held low, `data_out` shows a newly latched result one cycle after its `eoc` pulse.
- R11: While `rst` is high, the block is aborted and cleared on each clock edge. The clock edge after sampling `rst` high gives `busy`, `eoc` and `data_oe` all at 0, and both results cleared to 0.
- R12: `cs_n`, `rd_n` and `chan_sel` have no effect on when a conversion starts or how long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start; a falling edge starts a conversion, holding it low retriggers |
| pwr_dn | input | 1 | Power-down level; blocks new conversions only |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| chan_sel | input | 1 | Result to drive: 0 = channel A, 1 = channel B |
| sample_a | input | W | Channel A conversion word |
| sample_b | input | W | Channel B conversion word |
| busy | output | 1 | High while a conversion runs |
| eoc | output | 1 | One-cycle pulse after a channel result is latched |
| eoc_chan | output | 1 | Channel of the latest eoc: 0 = A, 1 = B |
| data_out | output | W | Parallel result bus (zero when not enabled) |
| data_oe | output | 1 | Bus output enable for the tri-state pads |

## Verification
The latencies of the results differ. `busy` rises one clock edge after the start edge is sampled. `eoc` and the latched result appear ACQ_CYC + CONVA_CYC cycles after that edge for channel A, and CONVB_CYC cycles later for channel B. Bus outputs follow `cs_n`, `rd_n`, `chan_sel` and the result registers one cycle later. The bench drives inputs on falling clock edges and advances a behavioural phase countdown on every rising edge. It compares all outputs on the next falling edge, so each comparison falls exactly in the cycle the value is due. Directed checks measure `busy` widths and the one-cycle retrigger gap by counting falling edges.

// File: rtl/dual_adc_pkg.sv
package dual_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACQ    = 2'd1,
    PH_CONV_A = 2'd2,
    PH_CONV_B = 2'd3
  } adc_phase_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
  import dual_adc_pkg::*;
#(
  parameter int ACQ_CYC   = 4,
  parameter int CONVA_CYC = 6,
  parameter int CONVB_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  input  logic pwr_dn,
  output logic cap_a,
  output logic cap_b,
  output logic busy,
  output logic eoc,
  output logic eoc_chan
);
  localparam int MAX_AB = (CONVA_CYC > CONVB_CYC) ? CONVA_CYC : CONVB_CYC;
  localparam int MAXC   = (ACQ_CYC > MAX_AB) ? ACQ_CYC : MAX_AB;
  localparam int CW     = $clog2(MAXC + 1);

  adc_phase_e       phase;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    lim_m1;
  logic             start_prev;
  logic             rearm;
  logic             last;
  logic             trig;

  always_comb begin
    case (phase)
      PH_ACQ:    lim_m1 = CW'(ACQ_CYC - 1);
      PH_CONV_A: lim_m1 = CW'(CONVA_CYC - 1);
      PH_CONV_B: lim_m1 = CW'(CONVB_CYC - 1);
      default:   lim_m1 = '0;
    endcase
  end

  assign last  = (cnt == lim_m1);
  assign cap_a = (phase == PH_CONV_A) && last;
  assign cap_b = (phase == PH_CONV_B) && last;
  assign trig  = (phase == PH_IDLE) && !start_n && (start_prev || rearm) && !pwr_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      start_prev <= 1'b1;
      rearm      <= 1'b0;
      busy       <= 1'b0;
      eoc        <= 1'b0;
      eoc_chan   <= 1'b0;
    end else begin
      start_prev <= start_n;
      eoc        <= cap_a | cap_b;
      rearm      <= cap_b & !start_n;
      if (cap_a) eoc_chan <= 1'b0;
      if (cap_b) eoc_chan <= 1'b1;
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (trig) begin
            phase <= PH_ACQ;
            busy  <= 1'b1;
          end
        end
        PH_ACQ: begin
          if (last) begin
            phase <= PH_CONV_A;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CONV_A: begin
          if (last) begin
            phase <= PH_CONV_B;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CONV_B: begin
          if (last) begin
            phase <= PH_IDLE;
            busy  <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import dual_adc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        wr,
  input  logic [NUM_CH-1:0][W-1:0] din,
  output logic [NUM_CH-1:0][W-1:0] q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)        r <= '0;
      else if (wr[c]) r <= din[c];
    end
    assign q[c] = r;
  end
endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         chan_sel,
  input  logic [W-1:0] res_a,
  input  logic [W-1:0] res_b,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  logic en;
  assign en = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= en;
      data_out <= en ? (chan_sel ? res_b : res_a) : '0;
    end
  end
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
  import dual_adc_pkg::*;
#(
  parameter int W         = 16,
  parameter int ACQ_CYC   = 4,
  parameter int CONVA_CYC = 6,
  parameter int CONVB_CYC = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n,
  input  logic         pwr_dn,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         chan_sel,
  input  logic [W-1:0] sample_a,
  input  logic [W-1:0] sample_b,
  output logic         busy,
  output logic         eoc,
  output logic         eoc_chan,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  logic                     cap_a;
  logic                     cap_b;
  logic [NUM_CH-1:0]        wr;
  logic [NUM_CH-1:0][W-1:0] din;
  logic [NUM_CH-1:0][W-1:0] res;

  assign wr  = {cap_b, cap_a};
  assign din = {sample_b, sample_a};

  adc_phase_ctrl #(
    .ACQ_CYC  (ACQ_CYC),
    .CONVA_CYC(CONVA_CYC),
    .CONVB_CYC(CONVB_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .pwr_dn  (pwr_dn),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .busy    (busy),
    .eoc     (eoc),
    .eoc_chan(eoc_chan)
  );

  adc_result_bank #(.W(W)) u_bank (
    .clk(clk),
    .rst(rst),
    .wr (wr),
    .din(din),
    .q  (res)
  );

  adc_bus_port #(.W(W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .chan_sel(chan_sel),
    .res_a   (res[0]),
    .res_b   (res[1]),
    .data_out(data_out),
    .data_oe (data_oe)
  );
endmodule

// File: rtl/dual_adc_seq_chk.sv
module dual_adc_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_n,
  input logic pwr_dn,
  input logic cs_n,
  input logic rd_n,
  input logic busy,
  input logic eoc,
  input logic eoc_chan,
  input logic data_oe
);
  logic past_ok;
  logic prev_start;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      past_ok    <= 1'b0;
      prev_start <= 1'b1;
    end else begin
      past_ok    <= 1'b1;
      prev_start <= start_n;
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!busy && !start_n && prev_start && !pwr_dn)) |-> busy); // R1
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc); // R3
  AST_EOC_A_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (eoc && !eoc_chan) |-> busy); // R3
  AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!busy && pwr_dn)) |-> !busy); // R6
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cs_n || rd_n)) |-> !data_oe); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    (rst_d === 1'b1) |-> (!busy && !eoc && !data_oe)); // R11
endmodule

bind dual_adc_seq dual_adc_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_n (start_n),
  .pwr_dn  (pwr_dn),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .busy    (busy),
  .eoc     (eoc),
  .eoc_chan(eoc_chan),
  .data_oe (data_oe)
);

// File: tb/dual_adc_seq_test.sv
`timescale 1ns/1ps
module dual_adc_seq_test;
  localparam int W   = 16;
  localparam int ACQ = 4;
  localparam int CA  = 6;
  localparam int CB  = 6;
  localparam int TOT = ACQ + CA + CB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start_n, pwr_dn, cs_n, rd_n, chan_sel;
  logic [W-1:0] sample_a, sample_b;
  logic busy, eoc, eoc_chan, data_oe;
  logic [W-1:0] data_out;

  dual_adc_seq #(.W(W), .ACQ_CYC(ACQ), .CONVA_CYC(CA), .CONVB_CYC(CB)) uut (
    .clk(clk), .rst(rst), .start_n(start_n), .pwr_dn(pwr_dn), .cs_n(cs_n),
    .rd_n(rd_n), .chan_sel(chan_sel), .sample_a(sample_a), .sample_b(sample_b),
    .busy(busy), .eoc(eoc), .eoc_chan(eoc_chan), .data_out(data_out),
    .data_oe(data_oe)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // changing sample words so capture timing is visible
  int scyc = 0;
  always @(negedge clk) begin
    scyc++;
    sample_a <= W'(scyc * 37 + 5);
    sample_b <= W'(scyc * 91 + 1000);
  end

  // behavioural reference: phase number with a countdown of cycles left
  bit m_ok = 0;
  int m_phase, m_left;
  bit m_prev, m_rearm, m_busy, m_eoc, m_ch, m_oe;
  int m_ra, m_rb, m_dout;

  always @(posedge clk) begin
    bit nrearm;
    m_ok = 1;
    if (rst) begin
      m_phase = 0; m_left = 0; m_prev = 1; m_rearm = 0; m_busy = 0;
      m_eoc = 0; m_ch = 0; m_oe = 0; m_ra = 0; m_rb = 0; m_dout = 0;
    end else begin
      m_oe   = !cs_n && !rd_n;
      m_dout = m_oe ? (chan_sel ? m_rb : m_ra) : 0;
      m_eoc  = 0;
      nrearm = 0;
      if (m_phase == 0) begin
        if (!start_n && (m_prev || m_rearm) && !pwr_dn) begin
          m_phase = 1; m_left = ACQ; m_busy = 1;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_phase == 1) begin
            m_phase = 2; m_left = CA;
          end else if (m_phase == 2) begin
            m_ra = int'(sample_a); m_eoc = 1; m_ch = 0; m_phase = 3; m_left = CB;
          end else begin
            m_rb = int'(sample_b); m_eoc = 1; m_ch = 1; m_phase = 0; m_busy = 0;
            nrearm = !start_n;
          end
        end
      end
      m_rearm = nrearm;
      m_prev  = start_n;
    end
  end

  // per-cycle comparison plus busy width / gap monitors
  int run = 0, last_w = 0, low_run = 0, last_gap = 0, rises = 0;
  bit busy_d = 0;
  always @(negedge clk) begin
    if (m_ok) begin
      chk("R1/R2 busy", busy, m_busy);
      chk("R3 eoc", eoc, m_eoc);
      chk("R3 eoc_chan", eoc_chan, m_ch);
      chk("R8 data_oe", data_oe, m_oe);
      chk("R9 data_out", int'(data_out), m_dout);
    end
    if (busy && !busy_d) begin
      rises++;
      last_gap = low_run;
    end
    if (busy) begin
      run++;
      low_run = 0;
    end else begin
      if (busy_d) begin
        last_w = run;
        run = 0;
      end
      low_run++;
    end
    busy_d = busy;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r0;
    bit got, pend;
    rst = 1; start_n = 1; pwr_dn = 0; cs_n = 1; rd_n = 1; chan_sel = 0;
    step(3);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset oe", data_oe, 0);
    chk("R11 reset eoc", eoc, 0);
    rst = 0;
    step(2);

    // R1 R2 R4: single conversion
    start_n = 0;
    step(1);
    chk("R1 busy after edge", busy, 1);
    start_n = 1;
    step(TOT + 2);
    chk("R2 busy width", last_w, TOT);

    // R9 R4: read both results
    cs_n = 0; rd_n = 0; chan_sel = 0;
    step(2);
    chk("R4 result A on bus", int'(data_out), m_ra);
    chk("R8 oe on", data_oe, 1);
    chan_sel = 1;
    step(1);
    chk("R9 channel B selected", int'(data_out), m_rb);
    chk("R4 result B on bus", int'(data_out), m_rb);
    cs_n = 1;
    step(1);
    chk("R8 oe off", data_oe, 0);
    chk("R8 bus zero", int'(data_out), 0);
    rd_n = 1;

    // R5: edge during busy not queued
    r0 = rises;
    start_n = 0; step(1); start_n = 1; step(3);
    start_n = 0; step(2); start_n = 1;
    step(TOT + 4);
    chk("R5 edge in busy ignored", rises - r0, 1);

    // R12: bus controls toggled during a conversion
    start_n = 0; step(1); start_n = 1;
    for (int i = 0; i < TOT; i++) begin
      cs_n = i[0]; rd_n = i[1]; chan_sel = i[2];
      step(1);
    end
    cs_n = 1; rd_n = 1;
    step(4);
    chk("R12 width with bus activity", last_w, TOT);

    // R6: power-down mid conversion, then while idle
    start_n = 0; step(1); start_n = 1; step(3);
    pwr_dn = 1;
    step(TOT + 2);
    chk("R6 conversion completes", last_w, TOT);
    start_n = 0; step(1); start_n = 1; step(5);
    chk("R6 start ignored in power-down", busy, 0);
    pwr_dn = 0;
    step(2);

    // R7 R10: self-retrigger with continuous read
    cs_n = 0; rd_n = 0; chan_sel = 0;
    r0 = rises; got = 0; pend = 0;
    start_n = 0;
    for (int i = 0; i < 3 * (TOT + 1) - 5; i++) begin
      step(1);
      if (pend) begin
        chk("R10 live result A", int'(data_out), m_ra);
        pend = 0;
      end else if (eoc && !eoc_chan && !got) begin
        got = 1;
        pend = 1;
      end
    end
    start_n = 1;
    step(TOT + 4);
    chk("R7 retrigger count", rises - r0, 3);
    chk("R7 one-cycle gap", last_gap, 1);
    chk("R10 live read seen", int'(got), 1);

    // R11: reset mid conversion
    cs_n = 1; rd_n = 1;
    start_n = 0; step(1); start_n = 1; step(6);
    rst = 1;
    step(1);
    chk("R11 abort busy", busy, 0);
    chk("R11 abort oe", data_oe, 0);
    rst = 0;
    step(3);
    chk("R11 no restart", busy, 0);
    cs_n = 0; rd_n = 0; chan_sel = 1;
    step(2);
    chk("R11 results cleared", int'(data_out), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule